// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

The block negates a stream of binary words, one bit per clock. Words enter least-significant bit first and follow one another with no idle bits required between them. A framing flag on the input marks the final bit of each word, so word length is set only by where that flag falls and can change from word to word. Each result bit leaves in the same cycle as the input bit that produced it. There is no pipeline register on the data path.

The rule is the usual serial form of "invert and add one". Output bits copy the input up to and including the first 1 in a word, and every later bit of that word is inverted. One carry flip-flop records whether that first 1 has been seen. The framing flag sets the carry back to 1, so the next word starts afresh. Reset also sets the carry to 1, never 0, so that the first word after reset is negated correctly.

Both sides use a valid/ready stream. A bit moves only in a cycle where in_valid and out_ready are both high. The block adds no buffering, so back-pressure passes straight through: in_ready follows out_ready, and out_valid follows in_valid, in the same cycle. While no transfer happens, the carry holds its value. out_bit still shows the result the presented bit would produce.

Top module: `serial_negator`

## Requirements
- R1: While rst is high at a clock edge, the carry is set to 1. The first bit transferred after reset therefore leaves with out_bit equal to in_bit.
- R2: out_bit is a function of the presented in_bit and the stored carry in the same cycle. It is in_bit while the carry is 1 and the inverse of in_bit while the carry is 0.
- R3: For each word of length L (1 to 16 in use) framed by in_last, the L transferred output bits, read least-significant first, equal (2^L - value) mod 2^L.
- R4: A transfer with in_last=1 reloads the carry to 1. The first bit of the next word therefore leaves equal to its input.
- R5: A word of one bit (in_last=1 on its only bit) leaves unchanged, and the word after it is also negated correctly.
- R6: In a cycle without a transfer (in_valid=0 or out_ready=0), the carry keeps its value.
- R7: in_ready equals out_ready, out_valid equals in_valid, and out_last equals in_last, all in the same cycle.
- R8: A transfer of in_bit=1 with in_last=0 clears the carry. Every later bit of the same word leaves inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; sets the carry to 1 |
| in_valid | input | 1 | Input bit is present |
| in_ready | output | 1 | Block can take the input bit (follows out_ready) |
| in_bit | input | 1 | Serial data bit, least-significant first |
| in_last | input | 1 | High on the final bit of a word |
| out_valid | output | 1 | Result bit is present (follows in_valid) |
| out_ready | input | 1 | Downstream takes the result bit |
| out_bit | output | 1 | Serial negated bit |
| out_last | output | 1 | High on the final result bit of a word |

## Verification
The carry is the only internal state, and out_bit depends on it directly. A wrong carry value therefore shows up on the very next presented bit. If the carry is stuck or fails to reload, the error appears at the first bit of the next word. If the carry changes during a stall, the error appears on the bit that resumes the transfer. If a 1 does not clear the carry, the error appears on the next bit of the same word. The bench compares every presented bit against a behavioural "first one seen" flag. It also compares each assembled word against its arithmetic negation modulo 2^L, with back-pressure and idle cycles applied at random.

// File: rtl/serial_negator_pkg.sv
package serial_negator_pkg;
  // Value the carry takes at reset and at every word boundary
  localparam logic CARRY_INIT = 1'b1;
endpackage

// File: rtl/sn_carry_reg.sv
module sn_carry_reg
  import serial_negator_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic bit_in,
  input  logic last_in,
  output logic carry_q
);
  always_ff @(posedge clk) begin
    if (rst)
      carry_q <= CARRY_INIT;
    else if (step)
      carry_q <= last_in | (carry_q & ~bit_in);
  end

  // R1: reset sets the carry
  a_r1_reset_preset: assert property (@(posedge clk) rst |=> carry_q);
  // R4: word end reloads the carry
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (step && last_in) |=> carry_q);
  // R8: a 1 in mid-word clears the carry
  a_r8_one_clears: assert property (@(posedge clk) disable iff (rst)
    (step && bit_in && !last_in) |=> !carry_q);
  // R6: without a transfer the carry holds
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(carry_q));
endmodule

// File: rtl/sn_out_logic.sv
module sn_out_logic (
  input  logic bit_in,
  input  logic carry_q,
  output logic bit_out
);
  // Inverted input plus the stored carry, summed without a carry-out
  assign bit_out = (~bit_in) ^ carry_q;
endmodule

// File: rtl/serial_negator.sv
module serial_negator (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_last,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_last
);
  logic xfer;
  logic carry;

  assign xfer      = in_valid & out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_last  = in_last;

  sn_carry_reg u_carry (
    .clk     (clk),
    .rst     (rst),
    .step    (xfer),
    .bit_in  (in_bit),
    .last_in (in_last),
    .carry_q (carry)
  );

  sn_out_logic u_out (
    .bit_in  (in_bit),
    .carry_q (carry),
    .bit_out (out_bit)
  );

  // R5: on a one-bit word that starts with the carry set, the input passes unchanged
  a_r5_single_passes: assert property (@(posedge clk) disable iff (rst)
    (xfer && in_last && carry) |-> (out_bit == in_bit));
endmodule

// File: tb/sim_serial_negator.sv
module sim_serial_negator;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_last = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_last;

  int nchk = 0;
  int nbad = 0;
  int cycles = 0;
  bit ended = 0;

  // behavioural model state
  bit seen_one = 0;
  bit after_reset = 1;

  always #10 clk = ~clk;

  serial_negator u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // push one bit; returns the output bit seen at transfer
  task automatic push_bit(input logic b, input logic l, input bit first, input bit single,
                          input bit stall_ok, output logic got);
    bit done = 0;
    bit stalled = 0;
    while (!done) begin
      @(negedge clk);
      in_valid  = stall_ok ? (($urandom % 4) != 0) : 1'b1;
      out_ready = stall_ok ? (($urandom % 4) != 0) : 1'b1;
      in_bit = b;
      in_last = l;
      #2;
      chk(in_ready == out_ready && out_valid == in_valid && out_last == in_last, "R7",
          {in_ready, out_valid, out_last}, {out_ready, in_valid, in_last});
      if (in_valid) begin
        logic exp_bit;
        string tag;
        exp_bit = seen_one ? ~b : b;
        if (after_reset && first) tag = "R1";
        else if (single)          tag = "R5";
        else if (first)           tag = "R4";
        else if (stalled)         tag = "R6";
        else if (seen_one)        tag = "R8";
        else                      tag = "R2";
        chk(out_bit === exp_bit, tag, out_bit, exp_bit);
      end
      if (in_valid && out_ready) begin
        done = 1;
        got = out_bit;
        after_reset = 0;
        if (l) seen_one = 0;
        else if (b) seen_one = 1;
      end else begin
        stalled = 1;
      end
    end
  endtask

  task automatic send_word(input int len, input int val, input bit stall_ok);
    int acc = 0;
    int expv;
    for (int i = 0; i < len; i++) begin
      logic g;
      push_bit(1'((val >> i) & 1), 1'(i == len - 1), i == 0, len == 1, stall_ok, g);
      acc = acc | (int'(g) << i);
    end
    expv = ((1 << len) - val) % (1 << len);
    chk(acc == expv, "R3", acc, expv);
    if (stall_ok && ($urandom % 3) == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    seen_one = 0;
    after_reset = 1;
  endtask

  initial begin
    logic dummy;
    do_reset();
    // R1: first word after reset, low bit is 0
    send_word(4, 4'b0110, 0);
    // R5: run of single-bit words
    send_word(1, 1, 0);
    send_word(1, 0, 0);
    send_word(1, 1, 0);
    // R3 corners: all zeros, all ones, top bit only
    send_word(8, 0, 0);
    send_word(8, 255, 0);
    send_word(16, 16'h8000, 0);
    send_word(16, 16'h0001, 0);
    // R1: reset in mid-word after the carry was cleared
    push_bit(1'b1, 1'b0, 1, 0, 0, dummy);
    push_bit(1'b0, 1'b0, 0, 0, 0, dummy);
    do_reset();
    send_word(3, 3'b010, 0);
    // random lengths and values with back-pressure
    for (int k = 0; k < 400; k++) begin
      int len;
      int val;
      len = 1 + ($urandom % 16);
      val = int'($urandom % (1 << len));
      send_word(len, val, 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule